// File: doc/BRIEF.md
# Receive FIFO Character Timeout Timer

This block raises the receive timeout condition for a FIFO-based serial receiver. It counts bit-time ticks while at least one character is waiting in the receive FIFO. When the count reaches a limit, it raises a timeout flag for the interrupt resolver. The limit depends on the programmed character length: twelve bit times plus four bit times per data bit.

The count goes back to zero on three events: the midpoint of every received stop bit, every read of the receive holding register, and an explicit clear. While the FIFO is empty the count is held at zero, so no timeout can ever appear with nothing to read. The timeout has the same interrupt priority as receive-data-ready. A second output therefore gives the flag already gated by the receive-data interrupt enable, ready for the resolver.

Top module: `rxto_timer`

## Requirements
- R1: After reset, with the FIFO not empty and no tick applied, `to_flag` and `to_irq` are low.
- R2: The limit in ticks is 4*(5+`wlen_sel`)+12: `wlen_sel` 0 gives 32, 1 gives 36, 2 gives 40 and 3 gives 44. After a restart, with the FIFO not empty, `to_flag` stays low through limit-1 ticks and is high once the limit-th tick has been registered.
- R3: While `fifo_empty` is high, `to_flag` is low in the same cycle and the count is held at zero. After `fifo_empty` falls, a full limit of ticks is needed again.
- R4: A `stop_mid` pulse restarts the count, so `to_flag` is low in the following cycle.
- R5: An `rhr_rd` pulse restarts the count in the same way.
- R6: A `clear` pulse restarts the count in the same way.
- R7: When a restart event and `bit_tick` fall in the same cycle, the restart wins and the count is zero afterwards.
- R8: Once the limit is reached, the count saturates and `to_flag` stays high under further ticks until a restart, an empty FIFO or a change of `wlen_sel`.
- R9: `to_irq` is high exactly when `to_flag` is high and `irq_en` is high.
- R10: The count advances only on cycles with `bit_tick` high. Idle cycles never bring the flag closer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per received bit time |
| wlen_sel | input | 2 | Character length select (5 + value data bits) |
| fifo_empty | input | 1 | Receive FIFO holds no character |
| stop_mid | input | 1 | Pulse at the centre of a received stop bit |
| rhr_rd | input | 1 | Pulse on a read of the receive holding register |
| clear | input | 1 | Pulse forcing a restart of the count |
| irq_en | input | 1 | Receive-data interrupt enable |
| to_flag | output | 1 | Timeout condition |
| to_irq | output | 1 | Timeout condition gated by `irq_en` |

## Verification
The two functions that can fall in one cycle are a restart event and the bit-time tick that would advance the count. The bench drives every restart source together with a tick in the same cycle. It then applies limit-1 further ticks and requires the flag to stay low, followed by one more tick that must raise it. If the tick had won, the flag would rise one tick early. This is repeated for every length setting and both enable values.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  // Ticks needed for a timeout at a given number of data bits
  function automatic int calc_limit(input int data_bits, input int per_bit, input int fixed);
    return per_bit * data_bits + fixed;
  endfunction

endpackage

// File: rtl/rxto_rst_sync.sv
module rxto_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/rxto_limit.sv
module rxto_limit
  import rxto_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int MIN_WLEN = 5,
  parameter int PER_BIT  = 4,
  parameter int FIXED    = 12,
  parameter int CNT_W    = 6
) (
  input  logic [SEL_W-1:0] wlen_sel,
  output logic [CNT_W-1:0] limit
);

  localparam int N_SEL = 1 << SEL_W;

  logic [CNT_W-1:0] lut [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_lut
    localparam int VAL = calc_limit(MIN_WLEN + g, PER_BIT, FIXED);
    assign lut[g] = CNT_W'(VAL);
  end

  assign limit = lut[wlen_sel];

endmodule

// File: rtl/rxto_restart.sv
module rxto_restart (
  input  logic stop_mid,
  input  logic rhr_rd,
  input  logic clear,
  input  logic fifo_empty,
  output logic restart,
  output logic hold
);

  always_comb begin
    restart = stop_mid | rhr_rd | clear;
    hold    = fifo_empty;
  end

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sat
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             zero_it;

  // Next-state: restart and hold take priority over the tick
  always_comb begin
    sat     = (cnt_q >= limit);
    zero_it = restart | hold;
    cnt_en  = zero_it | (tick & ~sat);
    cnt_d   = zero_it ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rxto_timer.sv
module rxto_timer
  import rxto_pkg::*;
#(
  parameter int WLEN_SEL_W = 2,
  parameter int MIN_WLEN   = 5,
  parameter int LIM_MUL    = 4,
  parameter int LIM_ADD    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_tick,
  input  logic [WLEN_SEL_W-1:0] wlen_sel,
  input  logic                  fifo_empty,
  input  logic                  stop_mid,
  input  logic                  rhr_rd,
  input  logic                  clear,
  input  logic                  irq_en,
  output logic                  to_flag,
  output logic                  to_irq
);

  localparam int MAX_WLEN  = MIN_WLEN + (1 << WLEN_SEL_W) - 1;
  localparam int MAX_LIMIT = calc_limit(MAX_WLEN, LIM_MUL, LIM_ADD);
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic             rst_n_int;
  logic             restart;
  logic             hold;
  logic             sat;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;

  rxto_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxto_limit #(
    .SEL_W    (WLEN_SEL_W),
    .MIN_WLEN (MIN_WLEN),
    .PER_BIT  (LIM_MUL),
    .FIXED    (LIM_ADD),
    .CNT_W    (CNT_W)
  ) u_limit (
    .wlen_sel (wlen_sel),
    .limit    (limit)
  );

  rxto_restart u_restart (
    .stop_mid   (stop_mid),
    .rhr_rd     (rhr_rd),
    .clear      (clear),
    .fifo_empty (fifo_empty),
    .restart    (restart),
    .hold       (hold)
  );

  rxto_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick    (bit_tick),
    .restart (restart),
    .hold    (hold),
    .limit   (limit),
    .cnt_q   (cnt_q),
    .sat     (sat)
  );

  always_comb begin
    to_flag = sat & ~fifo_empty;
    to_irq  = to_flag & irq_en;
  end

endmodule

// File: rtl/rxto_timer_chk.sv
module rxto_timer_chk #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic [SEL_W-1:0] wlen_sel,
  input logic             fifo_empty,
  input logic             stop_mid,
  input logic             rhr_rd,
  input logic             clear,
  input logic             irq_en,
  input logic             to_flag,
  input logic             to_irq,
  input logic [CNT_W-1:0] cnt_q
);

  assert_empty_holds_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> (cnt_q == '0));

  assert_stop_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mid |=> !to_flag);

  assert_read_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_rd |=> !to_flag);

  assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !to_flag);

  assert_restart_beats_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && (stop_mid || rhr_rd || clear)) |=> (cnt_q == '0));

  assert_flag_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !stop_mid && !rhr_rd && !clear)
      |=> (!$stable(wlen_sel) || fifo_empty || to_flag));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    to_irq |-> (to_flag && irq_en));

  assert_no_step_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> (cnt_q <= $past(cnt_q)));

endmodule

bind rxto_timer rxto_timer_chk #(
  .SEL_W (WLEN_SEL_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_tick   (bit_tick),
  .wlen_sel   (wlen_sel),
  .fifo_empty (fifo_empty),
  .stop_mid   (stop_mid),
  .rhr_rd     (rhr_rd),
  .clear      (clear),
  .irq_en     (irq_en),
  .to_flag    (to_flag),
  .to_irq     (to_irq),
  .cnt_q      (cnt_q)
);

// File: tb/rxto_timer_test.sv
module rxto_timer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic [1:0] wlen_sel;
  logic       fifo_empty;
  logic       stop_mid;
  logic       rhr_rd;
  logic       clear;
  logic       irq_en;
  logic       to_flag;
  logic       to_irq;

  int n_tests = 0;
  int n_fail  = 0;

  rxto_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .wlen_sel   (wlen_sel),
    .fifo_empty (fifo_empty),
    .stop_mid   (stop_mid),
    .rhr_rd     (rhr_rd),
    .clear      (clear),
    .irq_en     (irq_en),
    .to_flag    (to_flag),
    .to_irq     (to_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Flag and gated output together
  task automatic check_out(input string req, input logic exp_flag);
    check({req, " flag"}, to_flag, exp_flag);
    check({req, " irq R9"}, to_irq, exp_flag & irq_en);
  endtask

  // Entered right after a negedge, returns right after the next one
  task automatic cyc(input logic t, input logic s, input logic r, input logic c);
    bit_tick = t;
    stop_mid = s;
    rhr_rd   = r;
    clear    = c;
    @(negedge clk);
    bit_tick = 1'b0;
    stop_mid = 1'b0;
    rhr_rd   = 1'b0;
    clear    = 1'b0;
  endtask

  task automatic ticks(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      if (gaps && (i % 3 == 2)) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic restart_by(input int kind, input logic t);
    cyc(t, kind == 0, kind == 1, kind == 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    bit_tick   = 1'b0;
    wlen_sel   = 2'd0;
    fifo_empty = 1'b0;
    stop_mid   = 1'b0;
    rhr_rd     = 1'b0;
    clear      = 1'b0;
    irq_en     = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R1 reset", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1 after release", 1'b0);

    for (int sel = 0; sel < 4; sel++) begin
      for (int en = 0; en < 2; en++) begin
        for (int kind = 0; kind < 3; kind++) begin
          int lim;
          string rk;
          lim      = 4 * (5 + sel) + 12;
          wlen_sel = 2'(sel);
          irq_en   = en[0];
          rk       = (kind == 0) ? "R4 stop" : (kind == 1) ? "R5 read" : "R6 clear";

          // R2: exact limit
          cyc(1'b0, 1'b0, 1'b0, 1'b1);
          ticks(lim - 1, 1'b1);
          check_out("R2 below limit", 1'b0);
          ticks(1, 1'b0);
          check_out("R2 at limit", 1'b1);

          // R8: saturation
          ticks(5, 1'b0);
          check_out("R8 saturated", 1'b1);

          // R4/R5/R6: restart source
          restart_by(kind, 1'b0);
          check_out(rk, 1'b0);
          ticks(lim - 1, 1'b0);
          check_out({rk, " full limit again"}, 1'b0);
          ticks(1, 1'b0);
          check_out({rk, " limit after restart"}, 1'b1);

          // R7: restart together with tick
          restart_by(kind, 1'b1);
          ticks(lim - 1, 1'b0);
          check_out("R7 restart wins", 1'b0);
          ticks(1, 1'b0);
          check_out("R7 limit reached", 1'b1);

          // R10: idle cycles do not count
          cyc(1'b0, 1'b0, 1'b0, 1'b1);
          repeat (lim + 4) cyc(1'b0, 1'b0, 1'b0, 1'b0);
          check_out("R10 idle", 1'b0);

          // R3: empty FIFO
          ticks(lim - 1, 1'b0);
          fifo_empty = 1'b1;
          #1;
          check_out("R3 empty now", 1'b0);
          @(negedge clk);
          ticks(5, 1'b0);
          check_out("R3 ticks while empty", 1'b0);
          fifo_empty = 1'b0;
          ticks(lim - 1, 1'b0);
          check_out("R3 restarted from zero", 1'b0);
          ticks(1, 1'b0);
          check_out("R3 limit after empty", 1'b1);
          fifo_empty = 1'b1;
          #1;
          check_out("R3 flag drops same cycle", 1'b0);
          @(negedge clk);
          fifo_empty = 1'b0;
          #1;
          check_out("R3 count zeroed", 1'b0);
          @(negedge clk);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule